// File: doc/BRIEF.md
# Processor Thermal Throttle Controller

This block turns die temperature flags into the control signals that protect a multi-die processor. It reports an active-low "hot" indication whenever any die has crossed its configured trip point. It asserts a throttle request that goes to every core at the same time, and it can raise an interrupt when the hot state changes. The block only produces control signals. Temperature sensing, clock modulation and regulator sequencing are done elsewhere.

A platform can force throttling through an asynchronous active-low input. This input throttles the cores but never raises the hot indication. The block synchronizes it with two flops and measures how long each request lasts. A request shorter than a parameterized minimum sets a sticky warning bit. A separate catastrophic flag from any die latches an active-low shutdown output. This output does not depend on the monitor enable, and only reset clears it.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: `hot_n_o` is low exactly when at least one bit of `die_trip_i` was high at the previous clock edge.
- R2: With `mon_en_i` high, every bit of `throttle_o` goes high one edge after `hot_n_o` goes low. All cores always carry the same throttle value.
- R3: `force_n_i` passes through a two-flop synchronizer. With `mon_en_i` high, when `force_n_i` falls before an edge, all cores are throttled after the third edge.
- R4: Throttling caused by the force request persists while `force_n_i` stays low. It ends three edges after `force_n_i` rises, provided no die is hot.
- R5: The force request never changes `hot_n_o`.
- R6: `irq_cfg_i` selects the interrupt edges: 2'b00 none, 2'b01 hot assertion, 2'b10 hot deassertion, 2'b11 both. `irq_o` is a one-cycle pulse one edge after the selected change on `hot_n_o`.
- R7: `shutdown_n_o` goes low one edge after any bit of `die_crit_i` is high, whatever `mon_en_i` is. It stays low until reset.
- R8: With `mon_en_i` low, `throttle_o` stays zero for both hot and force causes. `hot_n_o` and `irq_o` keep operating.
- R9: `short_force_o` becomes high and stays high when a synchronized force request lasts fewer than `MIN_FORCE_CYC` cycles. A request of `MIN_FORCE_CYC` cycles or more leaves it low.
- R10: While `rst` is high and after it, until inputs change: `hot_n_o`=1, `shutdown_n_o`=1, `throttle_o`=0, `irq_o`=0, `short_force_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| die_trip_i | input | NUM_DIE | Per-die trip point reached |
| die_crit_i | input | NUM_DIE | Per-die catastrophic temperature reached |
| force_n_i | input | 1 | Asynchronous platform force-throttle request, active low |
| mon_en_i | input | 1 | Thermal monitor enable |
| irq_cfg_i | input | 2 | Interrupt edge selection |
| hot_n_o | output | 1 | Processor hot indication, active low |
| throttle_o | output | NUM_CORE | Throttle request per core |
| irq_o | output | 1 | Interrupt pulse on selected hot edges |
| shutdown_n_o | output | 1 | Latched thermal-trip shutdown, active low |
| short_force_o | output | 1 | Sticky warning: force request shorter than minimum |

## Verification
The hardest situation to reach is the overlap of a force request with a hot die, combined with changes of the enable. The throttle release then depends on both causes ending, and it must line up with the three-stage force path and the one-stage hot path. Random stimulus holds the die flags and the force input in runs of random length, toggles the enable and the interrupt mode now and then, and compares every cycle against a cycle model in the bench. Directed sequences then time the pulse-length boundary on both sides of `MIN_FORCE_CYC` and check that shutdown stays latched after the catastrophic flag drops.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_RISE = 2'b01,
        IRQ_FALL = 2'b10,
        IRQ_BOTH = 2'b11
    } irq_sel_e;

    typedef struct packed {
        logic now;
        logic prev;
    } hot_hist_t;

    // Pulse on the selected transition of the hot state
    function automatic logic irq_edge(irq_sel_e sel, hot_hist_t h);
        return (sel[0] & h.now & ~h.prev) | (sel[1] & ~h.now & h.prev);
    endfunction

endpackage

// File: rtl/tt_sync2.sv
module tt_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/tt_force_mon.sv
module tt_force_mon #(
    parameter int MIN_FORCE_CYC = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic force_n_async,
    output logic force_act_o,
    output logic short_o
);
    localparam int CNT_W = $clog2(MIN_FORCE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_FORCE_CYC);

    logic             force_n_s;
    logic [CNT_W-1:0] len_q;
    logic             short_q;

    tt_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (force_n_async),
        .q_o (force_n_s)
    );

    assign force_act_o = ~force_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            short_q <= 1'b0;
        end else if (force_act_o) begin
            if (len_q != CNT_MAX) len_q <= len_q + 1'b1;
        end else begin
            if (len_q != '0 && len_q < CNT_MAX) short_q <= 1'b1;
            len_q <= '0;
        end
    end

    assign short_o = short_q;

    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        short_q |=> short_q); // R9
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        len_q <= CNT_MAX); // R9
endmodule

// File: rtl/tt_hot_irq.sv
module tt_hot_irq
    import thermal_pkg::*;
#(
    parameter int NUM_DIE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DIE-1:0] die_trip_i,
    input  logic [1:0]         irq_cfg_i,
    output logic               hot_o,
    output logic               irq_o
);
    hot_hist_t hist_q;
    logic      irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            hist_q.now  <= |die_trip_i;
            hist_q.prev <= hist_q.now;
            irq_q       <= irq_edge(irq_sel_e'(irq_cfg_i), hist_q);
        end
    end

    assign hot_o = hist_q.now;
    assign irq_o = irq_q;

    AST_HOT_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (hist_q.now == $past(|die_trip_i))); // R1
    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(hist_q.now) != $past(hist_q.prev))); // R6
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
    parameter int NUM_DIE       = 2,
    parameter int NUM_CORE      = 8,
    parameter int MIN_FORCE_CYC = 125000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_DIE-1:0]  die_trip_i,
    input  logic [NUM_DIE-1:0]  die_crit_i,
    input  logic                force_n_i,
    input  logic                mon_en_i,
    input  logic [1:0]          irq_cfg_i,
    output logic                hot_n_o,
    output logic [NUM_CORE-1:0] throttle_o,
    output logic                irq_o,
    output logic                shutdown_n_o,
    output logic                short_force_o
);
    logic hot, force_act, trip_q;
    logic [NUM_CORE-1:0] thr_q;

    tt_hot_irq #(.NUM_DIE(NUM_DIE)) u_hot (
        .clk        (clk),
        .rst        (rst),
        .die_trip_i (die_trip_i),
        .irq_cfg_i  (irq_cfg_i),
        .hot_o      (hot),
        .irq_o      (irq_o)
    );

    tt_force_mon #(.MIN_FORCE_CYC(MIN_FORCE_CYC)) u_force (
        .clk           (clk),
        .rst           (rst),
        .force_n_async (force_n_i),
        .force_act_o   (force_act),
        .short_o       (short_force_o)
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst) thr_q[c] <= 1'b0;
            else     thr_q[c] <= mon_en_i & (hot | force_act);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              trip_q <= 1'b0;
        else if (|die_crit_i) trip_q <= 1'b1;
    end

    assign hot_n_o      = ~hot;
    assign throttle_o   = thr_q;
    assign shutdown_n_o = ~trip_q;

    AST_CORES_AGREE: assert property (@(posedge clk) disable iff (rst)
        (thr_q == '0) || (&thr_q)); // R2
    AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (force_act && mon_en_i) |=> (&thr_q)); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mon_en_i |=> (thr_q == '0)); // R8
    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
        trip_q |=> trip_q); // R7
    AST_TRIP_SET: assert property (@(posedge clk) disable iff (rst)
        (|die_crit_i) |=> !shutdown_n_o); // R7
endmodule

// File: tb/thermal_throttle_ctrl_bench.sv
module thermal_throttle_ctrl_bench;
    localparam int ND = 2;
    localparam int NC = 4;
    localparam int MINP = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ND-1:0] die_trip = '0, die_crit = '0;
    logic force_n = 1'b1, mon_en = 1'b0;
    logic [1:0] irq_cfg = 2'b00;
    logic hot_n, irq, shut_n, short_f;
    logic [NC-1:0] thr;

    int total = 0, bad = 0, cyc = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    thermal_throttle_ctrl #(.NUM_DIE(ND), .NUM_CORE(NC), .MIN_FORCE_CYC(MINP)) u_thermal_throttle_ctrl (
        .clk(clk), .rst(rst), .die_trip_i(die_trip), .die_crit_i(die_crit),
        .force_n_i(force_n), .mon_en_i(mon_en), .irq_cfg_i(irq_cfg),
        .hot_n_o(hot_n), .throttle_o(thr), .irq_o(irq),
        .shutdown_n_o(shut_n), .short_force_o(short_f));

    // Cycle model derived from R1..R10
    logic m_s1, m_s2, m_hot, m_hotp, m_irq, m_thr, m_trip, m_short;
    int   m_len;

    function automatic logic exp_irq(logic [1:0] cfg, logic now, logic prev);
        return (cfg[0] && now && !prev) || (cfg[1] && !now && prev);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_hot <= 0; m_hotp <= 0; m_irq <= 0;
            m_thr <= 0; m_trip <= 0; m_short <= 0; m_len <= 0;
        end else begin
            m_s1   <= !force_n;
            m_s2   <= m_s1;
            m_hot  <= |die_trip;
            m_hotp <= m_hot;
            m_irq  <= exp_irq(irq_cfg, m_hot, m_hotp);
            m_thr  <= mon_en && (m_hot || m_s2);
            if (|die_crit) m_trip <= 1;
            if (m_s2) m_len <= (m_len < MINP) ? m_len + 1 : m_len;
            else begin
                if (m_len != 0 && m_len < MINP) m_short <= 1;
                m_len <= 0;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (model_on && !rst) begin
            chk("R1", hot_n, !m_hot);
            chk("R2", thr, m_thr ? {NC{1'b1}} : '0);
            chk("R6", irq, m_irq);
            chk("R7", shut_n, !m_trip);
            chk("R9", short_f, m_short);
        end
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        die_trip = '0; die_crit = '0; force_n = 1'b1;
        step(3); rst = 1'b0;
    endtask

    initial begin
        int seed;
        seed = 32'd1234;
        void'($urandom(seed));
        do_reset();
        // R10 reset state
        chk("R10 hot_n", hot_n, 1); chk("R10 thr", thr, 0); chk("R10 irq", irq, 0);
        chk("R10 shut_n", shut_n, 1); chk("R10 short", short_f, 0);

        // R3 / R4 / R5: force path timing with monitor on
        mon_en = 1'b1;
        force_n = 1'b0;
        step(2); chk("R3 before third edge", thr, 0);
        step(1); chk("R3 all cores", thr, {NC{1'b1}});
        chk("R5 hot untouched", hot_n, 1);
        step(MINP + 5); chk("R4 held", thr, {NC{1'b1}});
        force_n = 1'b1;
        step(2); chk("R4 still on", thr, {NC{1'b1}});
        step(1); chk("R4 released", thr, 0);
        chk("R9 long pulse no warn", short_f, 0);

        // R9 short pulse
        force_n = 1'b0; step(5); force_n = 1'b1; step(5);
        chk("R9 short pulse warn", short_f, 1);
        step(3); chk("R9 sticky", short_f, 1);

        // R8 disabled monitor: hot works, no throttle, irq works
        do_reset();
        mon_en = 1'b0; irq_cfg = 2'b01;
        die_trip = 2'b10;
        step(1); chk("R8 hot", hot_n, 0); chk("R8 thr off", thr, 0);
        step(1); chk("R8 irq", irq, 1);
        step(1); chk("R6 single pulse", irq, 0);
        force_n = 1'b0; step(6); chk("R8 force no thr", thr, 0);
        force_n = 1'b1; die_trip = '0; step(4);

        // R7 crit latch with monitor off
        die_crit = 2'b01; step(1); die_crit = '0;
        chk("R7 shutdown", shut_n, 0);
        step(10); chk("R7 latched", shut_n, 0);

        // Random phase checked against the cycle model
        do_reset();
        model_on = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8)       die_trip = 2'($urandom_range(0, 3));
            else if (r < 12) force_n = ~force_n;
            else if (r < 14) mon_en = ~mon_en;
            else if (r < 16) irq_cfg = 2'($urandom_range(0, 3));
            else if (r == 99 && i > 4000) die_crit = 2'($urandom_range(1, 3));
            else die_crit = '0;
            step(1);
        end
        model_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule